// File: doc/BRIEF.md
# Halving Tree Reduction Sequencer

This block adds up a list of signed integers held in a small register array. It does not use a single wide adder. Instead it folds the array onto itself one round at a time, which models a group of parallel lanes working on shared storage. A start pulse captures the element count and all the element values in a single cycle. The block then runs reduction rounds until only one live slot is left. Each round has two phases. The first is a barrier cycle, in which nothing changes. The second is an update cycle, in which every active lane adds the slot lying one half-span above its own slot.

The number of live slots does not have to be a power of two. When the live count of a round is odd, lane 0 also absorbs the last live slot during that round's update. Every addition in an update reads values that were registered before that cycle, so no lane ever sees a partial result from another lane. The result is as wide as the element width plus ceil(log2 N) bits, so no sum can overflow. When the result is ready, the block raises a one-cycle completion pulse and reports how many rounds it ran.

Top module: `treeReduce`

## Requirements
- R1: While reset is held and right after it is released, `done` is 0, `round` is 0 and `sum` is 0.
- R2: When `done` is high, `sum` equals the exact signed sum of the first `count` elements. Each element is the W-bit two's-complement field `elemIn[i*W +: W]`, sign-extended to the result width without overflow.
- R3: Elements at index `count` or above contribute nothing. A `count` larger than N is treated as N.
- R4: Counts that are not powers of two reduce correctly. On a round whose live count is odd, lane 0 folds in the last live element.
- R5: `round` is cleared when a start is accepted and rises by one per halving round. At `done` it equals floor(log2(count)), or 0 for a count of 0 or 1.
- R6: Each round is one barrier cycle followed by one update cycle. The start is captured at rising edge 1, and `done` is first high right after rising edge 2*R+1, where R is the round count.
- R7: `done` stays high for exactly one cycle per accepted start.
- R8: A `start` that arrives while a reduction is in progress is ignored. The result, the round count and the completion timing stay those of the run already under way.
- R9: A count of 1 yields element 0 as the result, and a count of 0 yields 0. In both cases `done` comes right after the capture edge and no rounds are run.
- R10: `elemIn` and `count` are sampled only on the edge that accepts a start. Later changes to them do not alter the run.
- R11: After `done`, `sum` and `round` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests a new reduction; accepted only when idle |
| count | input | $clog2(N+1) | Number of elements to reduce |
| elemIn | input | N*W | Flat element array; element i sits at bits [i*W +: W] |
| sum | output | W+$clog2(N) | Signed result, read when done is high |
| done | output | 1 | One-cycle pulse marking a valid result |
| round | output | $clog2($clog2(N)+1) | Number of rounds completed in the current or last run |

## Verification
The bench builds the block with N = 13 and W = 8. With these values every count from 0 up to N, and one count above N, can be run in a short time. Thirteen is odd and not a power of two, so a single run passes through live counts 13, 6, 3 and 1, which exercises both the odd-fold path and the even path. With an 8-bit element width, all-minimum and all-maximum inputs reach the top of the 12-bit result range, so the sign extension and the widened result are both tested at their limits.

// File: rtl/trsPkg.sv
package trsPkg;

  // Strobes sent from the sequencer to the slot array
  typedef struct packed {
    logic load;   // capture elements and clear unused slots
    logic step;   // apply one round of lane additions
  } trsStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BARRIER = 2'd1,
    ST_UPDATE  = 2'd2,
    ST_FINISH  = 2'd3
  } trsStateT;

endpackage

// File: rtl/treeRedCtrl.sv
module treeRedCtrl
  import trsPkg::*;
#(
  parameter int N  = 100,
  localparam int CW = $clog2(N + 1),
  localparam int RW = $clog2($clog2(N) + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] count,
  output trsStrobeT     ctl,
  output logic [CW-1:0] half,
  output logic [CW-1:0] effCnt,
  output logic [RW-1:0] round,
  output logic          done
);

  trsStateT      state;
  logic [CW-1:0] halfNext;

  assign effCnt   = (count > CW'(N)) ? CW'(N) : count;
  assign halfNext = half >> 1;
  assign done     = (state == ST_FINISH);

  always_comb begin
    ctl      = '0;
    ctl.load = (state == ST_IDLE) && start;
    ctl.step = (state == ST_UPDATE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      half  <= '0;
      round <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            half  <= effCnt;
            round <= '0;
            state <= (effCnt <= CW'(1)) ? ST_FINISH : ST_BARRIER;
          end
        end
        ST_BARRIER: state <= ST_UPDATE;
        ST_UPDATE: begin
          half  <= halfNext;
          round <= round + RW'(1);
          state <= (halfNext == CW'(1)) ? ST_FINISH : ST_BARRIER;
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  barrier_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UPDATE) |-> $past(state == ST_BARRIER));

  // R5
  round_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> (round == $past(round) + RW'(1)));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && state != ST_IDLE) |=> (round >= $past(round)));

  // R9
  short_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && effCnt <= CW'(1)) |=> done);

endmodule

// File: rtl/treeRedData.sv
module treeRedData
  import trsPkg::*;
#(
  parameter int N  = 100,
  parameter int W  = 16,
  localparam int CW = $clog2(N + 1),
  localparam int AW = W + $clog2(N),
  localparam int LANES = N / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trsStrobeT            ctl,
  input  logic [CW-1:0]        half,
  input  logic [CW-1:0]        effCnt,
  input  logic [N*W-1:0]       elemIn,
  output logic signed [AW-1:0] sum
);

  logic signed [AW-1:0] slot    [N];
  logic signed [AW-1:0] laneSum [LANES];
  logic [LANES-1:0]     active;
  logic [CW-1:0]        nextHalf;
  logic [CW-1:0]        foldIdx;
  logic signed [AW-1:0] foldVal;

  assign nextHalf = half >> 1;
  assign foldIdx  = half - CW'(1);
  assign foldVal  = half[0] ? slot[foldIdx] : '0;
  assign sum      = slot[0];

  // One adder per lane; partner is always below the current half-count
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [CW-1:0] partIdx;
    assign partIdx   = CW'(g) + nextHalf;
    assign active[g] = CW'(g) < nextHalf;
    if (g == 0) begin : gFold
      assign laneSum[g] = slot[0] + slot[partIdx] + foldVal;
    end else begin : gPlain
      assign laneSum[g] = slot[g] + slot[partIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) slot[i] <= '0;
    end else if (ctl.load) begin
      for (int i = 0; i < N; i++) begin
        if (CW'(i) < effCnt)
          slot[i] <= {{(AW-W){elemIn[i*W+W-1]}}, elemIn[i*W +: W]};
        else
          slot[i] <= '0;
      end
    end else if (ctl.step) begin
      for (int i = 0; i < LANES; i++) begin
        if (active[i]) slot[i] <= laneSum[i];
      end
    end
  end

  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> $stable(sum));

  // R3
  clear_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && effCnt == '0) |=> (sum == '0));

endmodule

// File: rtl/treeReduce.sv
module treeReduce
  import trsPkg::*;
#(
  parameter int N  = 100,
  parameter int W  = 16,
  localparam int CW = $clog2(N + 1),
  localparam int AW = W + $clog2(N),
  localparam int RW = $clog2($clog2(N) + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [CW-1:0]        count,
  input  logic [N*W-1:0]       elemIn,
  output logic signed [AW-1:0] sum,
  output logic                 done,
  output logic [RW-1:0]        round
);

  trsStrobeT     ctl;
  logic [CW-1:0] half;
  logic [CW-1:0] effCnt;

  treeRedCtrl #(.N(N)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .count  (count),
    .ctl    (ctl),
    .half   (half),
    .effCnt (effCnt),
    .round  (round),
    .done   (done)
  );

  treeRedData #(.N(N), .W(W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .half   (half),
    .effCnt (effCnt),
    .elemIn (elemIn),
    .sum    (sum)
  );

endmodule

// File: tb/treeReduce_test.sv
module treeReduce_test;

  localparam int N  = 13;
  localparam int W  = 8;
  localparam int CW = $clog2(N + 1);
  localparam int AW = W + $clog2(N);
  localparam int RW = $clog2($clog2(N) + 1);
  localparam int NV = 10;
  // count, pattern, expected rounds
  localparam int TBL [NV][3] = '{
    '{1, 0, 0}, '{2, 1, 1}, '{3, 4, 1}, '{4, 1, 2}, '{5, 2, 2},
    '{7, 4, 2}, '{8, 0, 3}, '{13, 3, 3}, '{12, 1, 3}, '{13, 2, 3}
  };

  logic                 clk = 0;
  logic                 rstN = 0;
  logic                 start = 0;
  logic [CW-1:0]        count = '0;
  logic [N*W-1:0]       elemIn = '0;
  logic signed [AW-1:0] sum;
  logic                 done;
  logic [RW-1:0]        round;

  int checks = 0;
  int fails  = 0;

  treeReduce #(.N(N), .W(W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .count(count),
    .elemIn(elemIn), .sum(sum), .done(done), .round(round)
  );

  always #10 clk = ~clk;

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] patVal(input int pat, input int idx);
    case (pat)
      0:       return W'(idx + 1);
      1:       return (idx % 2 == 1) ? W'(-(idx * 9)) : W'(idx * 7 + 3);
      2:       return {1'b1, {(W-1){1'b0}}};
      3:       return {1'b0, {(W-1){1'b1}}};
      default: return W'(idx * 37 + 11);
    endcase
  endfunction

  // cnt may exceed N; poke fires a second start while busy
  task automatic runCase(input string tag, input int cnt, input int pat,
                         input int rounds, input bit poke);
    int expSum = 0;
    int edges  = 1;
    for (int j = 0; j < N; j++) begin
      elemIn[j*W +: W] = (j < cnt) ? patVal(pat, j) : W'(8'h5A);
      if (j < cnt) expSum += int'($signed(patVal(pat, j)));
    end
    count = CW'(cnt);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    // R10: disturb inputs once captured
    elemIn = {N{W'(8'h3C)}};
    count  = CW'(2);
    while (!done && edges < 60) begin
      if (poke && edges == 1) start = 1;
      @(negedge clk);
      start = 0;
      edges++;
    end
    checkEq({tag, " R6 latency"}, edges, 2 * rounds + 1);
    checkEq({tag, " R2 R4 R10 sum"}, int'(sum), expSum);
    checkEq({tag, " R5 rounds"}, int'(round), rounds);
    @(negedge clk);
    checkEq({tag, " R7 done pulse"}, int'(done), 0);
    checkEq({tag, " R11 sum hold"}, int'(sum), expSum);
    checkEq({tag, " R11 round hold"}, int'(round), rounds);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R1 done in reset", int'(done), 0);
    rstN = 1;
    @(negedge clk);
    checkEq("R1 done", int'(done), 0);
    checkEq("R1 round", int'(round), 0);
    checkEq("R1 sum", int'(sum), 0);

    for (int v = 0; v < NV; v++)
      runCase($sformatf("vec%0d", v), TBL[v][0], TBL[v][1], TBL[v][2], 1'b0);

    runCase("R9 zero", 0, 0, 0, 1'b0);
    runCase("R9 one", 1, 3, 0, 1'b0);
    runCase("R3 clamp", 15, 4, 3, 1'b0);
    runCase("R8 busy", 13, 4, 3, 1'b1);
    runCase("R8 busy short", 3, 1, 1, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule